// File: doc/BRIEF.md
# Conditional Branch Resolver with Condition-Bit Interlock

This block decides the direction of conditional branches that test one bit of a 32-bit condition register. It keeps a count of in-flight writers for every condition bit. When a branch arrives and its bit has no older writer outstanding, the block reads the bit and reports the final direction in the next cycle.

When an older writer is still in flight, the block reports a statically predicted direction instead, flagged as speculative, so fetch can carry on along that path. It then watches the writebacks to that bit. When the last older writer completes, the block compares the written value against its guess. A correct guess retires quietly. A wrong guess raises a one-cycle flush together with a one-cycle redirect, which carries the alternate-path address captured when the guess was made.

Only one speculative branch may be outstanding. A later branch is stalled until the first one retires.

Top module: `br_resolve_unit`

## Requirements
- R1: After reset, `busy`, `res_vld`, `flush`, `redirect` and `br_stall` are all 0, every condition bit reads 0 and no bit has a pending writer.
- R2: A branch accepted while its bit has no older pending writer gives `res_vld`=1 and `res_spec`=0 in the next cycle. `res_taken` is 1 exactly when the condition bit equals `br_sense`. `busy` stays 0.
- R3: A branch accepted while its bit has an older pending writer gives `res_vld`=1, `res_spec`=1 and `res_taken` = `br_backward` XOR `br_hint` in the next cycle, and `busy` becomes 1 in that same cycle.
- R4: A writeback that retires the last pending writer of the tested bit in the same cycle as the branch is forwarded. The branch then resolves as in R2, using the written value.
- R5: Each `wr_issue_vld` adds one pending writer to bit `wr_issue_idx`, and each writeback to that bit removes one. A bit stays interlocked until as many writebacks as issues have arrived. An issue and a writeback to the same bit in one cycle leave its count unchanged.
- R6: When the last older writer of a speculated branch writes back a value that agrees with the prediction, `busy` drops in the next cycle and neither `flush` nor `redirect` is raised.
- R7: When that value disagrees with the prediction, `flush` and `redirect` are both 1 for exactly one cycle, in the cycle after the writeback, and `busy` drops in that same cycle. `redirect_addr` then holds `br_fallthru` if the prediction was taken and `br_target` if it was not.
- R8: `br_stall` is 1 exactly when `br_vld` is 1 while `busy` is 1. A stalled branch is not accepted and produces no `res_vld` in the next cycle.
- R9: Writers to the tested bit that issue after a speculated branch was accepted do not delay its resolution. It resolves on the writeback that retires the last writer that was pending when it was accepted.
- R10: A writeback to a bit with no pending writer leaves that bit's count at zero, but its value still becomes the bit's condition value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_issue_vld | input | 1 | A condition-bit writer enters the pipelines |
| wr_issue_idx | input | 5 | Bit that writer will update |
| wb_vld | input | 1 | A condition-bit writer completes |
| wb_idx | input | 5 | Bit being written back |
| wb_val | input | 1 | Value written to that bit |
| br_vld | input | 1 | A conditional branch is presented |
| br_idx | input | 5 | Condition bit the branch tests |
| br_sense | input | 1 | Bit value that makes the branch taken |
| br_backward | input | 1 | Displacement is negative |
| br_hint | input | 1 | Invert the static default |
| br_target | input | 32 | Taken-path address |
| br_fallthru | input | 32 | Not-taken-path address |
| br_stall | output | 1 | Branch held back; present it again later |
| busy | output | 1 | A speculated branch awaits its condition bit |
| res_vld | output | 1 | Direction report for the accepted branch |
| res_taken | output | 1 | Reported direction |
| res_spec | output | 1 | Reported direction is a prediction |
| flush | output | 1 | Purge everything fetched after the branch |
| redirect | output | 1 | Restart fetch at `redirect_addr` |
| redirect_addr | output | 32 | Alternate-path address |

## Verification
The checker watches, on every cycle, the handshake-level invariants: stall coincides with a branch arriving while busy, a stalled branch never yields a report, and a speculative report always comes with busy while a direct one never does. It also checks that flush follows a busy cycle, ends busy and never lasts two cycles. Whether the direction, the forwarded value, the redirect address and the timing of the retiring writeback are right depends on the history of issues and writebacks per bit. Only the bench's directed cases can show these, together with its randomized stream compared cycle by cycle against a behavioural model.

// File: rtl/brc_pkg.sv
package brc_pkg;
    // state of the single outstanding-branch tracker
    typedef enum logic [0:0] {
        TRK_IDLE = 1'b0,
        TRK_WAIT = 1'b1
    } trk_state_e;

    // static direction guess: backward branches are taken by default, hint flips it
    function automatic logic static_guess(input logic backward, input logic hint);
        return backward ^ hint;
    endfunction
endpackage

// File: rtl/brc_scoreboard.sv
module brc_scoreboard #(
    parameter int CR_BITS = 32,
    parameter int CNT_W   = 3,
    localparam int IDX_W  = $clog2(CR_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wb_vld,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic             wb_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt_next,
    output logic             rd_val_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CR_BITS-1:0][CNT_W-1:0] cnt;
        logic [CR_BITS-1:0]            cr;
    } sb_t;

    sb_t sb_d, sb_q;
    logic [CR_BITS-1:0] inc_hit;
    logic [CR_BITS-1:0] dec_hit;

    // one-hot decode of the issue and writeback indices
    for (genvar g = 0; g < CR_BITS; g++) begin : g_bit
        assign inc_hit[g] = wr_vld && (wr_idx == IDX_W'(g));
        assign dec_hit[g] = wb_vld && (wb_idx == IDX_W'(g));
    end

    always_comb begin
        sb_d = sb_q;
        for (int i = 0; i < CR_BITS; i++) begin
            case ({inc_hit[i], dec_hit[i]})
                2'b10: if (sb_q.cnt[i] != CNT_MAX) sb_d.cnt[i] = sb_q.cnt[i] + 1'b1;
                2'b01: if (sb_q.cnt[i] != '0)      sb_d.cnt[i] = sb_q.cnt[i] - 1'b1;
                // a writeback on an idle bit is stray; the new issue still counts
                2'b11: if (sb_q.cnt[i] == '0)      sb_d.cnt[i] = CNT_W'(1);
                default: ;
            endcase
            if (dec_hit[i]) sb_d.cr[i] = wb_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    // read the post-update view so same-cycle writebacks are forwarded
    assign rd_cnt_next = sb_d.cnt[rd_idx];
    assign rd_val_next = sb_d.cr[rd_idx];
endmodule

// File: rtl/brc_predictor.sv
module brc_predictor #(
    parameter int ADDR_W = 32
) (
    input  logic              backward,
    input  logic              hint,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] fallthru,
    output logic              guess_taken,
    output logic [ADDR_W-1:0] alt_addr
);
    import brc_pkg::*;

    always_comb begin
        guess_taken = static_guess(backward, hint);
        // the path fetch must fall back to if the guess turns out wrong
        alt_addr    = guess_taken ? fallthru : target;
    end
endmodule

// File: rtl/brc_tracker.sv
module brc_tracker #(
    parameter int CR_BITS = 32,
    parameter int CNT_W   = 3,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(CR_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_vld,
    input  logic [IDX_W-1:0]  br_idx,
    input  logic              br_sense,
    input  logic              guess_taken,
    input  logic [ADDR_W-1:0] alt_addr,
    input  logic [CNT_W-1:0]  rd_cnt_next,
    input  logic              rd_val_next,
    input  logic              wb_vld,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic              wb_val,
    output logic              br_stall,
    output logic              busy,
    output logic              res_vld,
    output logic              res_taken,
    output logic              res_spec,
    output logic              flush,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_addr
);
    import brc_pkg::*;

    typedef struct packed {
        trk_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic              sense;
        logic              guess;
        logic [CNT_W-1:0]  older;   // writers still owed to the waiting branch
        logic [ADDR_W-1:0] alt;
        logic              res_vld;
        logic              res_taken;
        logic              res_spec;
        logic              flush;
        logic              redirect;
        logic [ADDR_W-1:0] redir_addr;
    } trk_t;

    trk_t t_d, t_q;
    logic accept;
    logic own_wb;
    logic actual;

    assign accept = br_vld && (t_q.st == TRK_IDLE);
    assign own_wb = wb_vld && (wb_idx == t_q.idx) && (t_q.older != '0);
    assign actual = (wb_val == t_q.sense);

    always_comb begin
        t_d          = t_q;
        t_d.res_vld  = 1'b0;
        t_d.flush    = 1'b0;
        t_d.redirect = 1'b0;
        if (t_q.st == TRK_WAIT) begin
            if (own_wb) begin
                t_d.older = t_q.older - 1'b1;
                if (t_q.older == CNT_W'(1)) begin
                    t_d.st = TRK_IDLE;
                    if (actual != t_q.guess) begin
                        t_d.flush      = 1'b1;
                        t_d.redirect   = 1'b1;
                        t_d.redir_addr = t_q.alt;
                    end
                end
            end
        end else if (accept) begin
            t_d.res_vld = 1'b1;
            if (rd_cnt_next == '0) begin
                t_d.res_spec  = 1'b0;
                t_d.res_taken = (rd_val_next == br_sense);
            end else begin
                t_d.st        = TRK_WAIT;
                t_d.idx       = br_idx;
                t_d.sense     = br_sense;
                t_d.guess     = guess_taken;
                t_d.older     = rd_cnt_next;
                t_d.alt       = alt_addr;
                t_d.res_spec  = 1'b1;
                t_d.res_taken = guess_taken;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign br_stall      = br_vld && (t_q.st == TRK_WAIT);
    assign busy          = (t_q.st == TRK_WAIT);
    assign res_vld       = t_q.res_vld;
    assign res_taken     = t_q.res_taken;
    assign res_spec      = t_q.res_spec;
    assign flush         = t_q.flush;
    assign redirect      = t_q.redirect;
    assign redirect_addr = t_q.redir_addr;
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit #(
    parameter int CR_BITS = 32,
    parameter int CNT_W   = 3,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(CR_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_issue_vld,
    input  logic [IDX_W-1:0]  wr_issue_idx,
    input  logic              wb_vld,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic              wb_val,
    input  logic              br_vld,
    input  logic [IDX_W-1:0]  br_idx,
    input  logic              br_sense,
    input  logic              br_backward,
    input  logic              br_hint,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [ADDR_W-1:0] br_fallthru,
    output logic              br_stall,
    output logic              busy,
    output logic              res_vld,
    output logic              res_taken,
    output logic              res_spec,
    output logic              flush,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_addr
);
    logic [CNT_W-1:0]  rd_cnt_next;
    logic              rd_val_next;
    logic              guess_taken;
    logic [ADDR_W-1:0] alt_addr;

    brc_scoreboard #(.CR_BITS(CR_BITS), .CNT_W(CNT_W)) i_sb (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_vld      (wr_issue_vld),
        .wr_idx      (wr_issue_idx),
        .wb_vld      (wb_vld),
        .wb_idx      (wb_idx),
        .wb_val      (wb_val),
        .rd_idx      (br_idx),
        .rd_cnt_next (rd_cnt_next),
        .rd_val_next (rd_val_next)
    );

    brc_predictor #(.ADDR_W(ADDR_W)) i_pred (
        .backward    (br_backward),
        .hint        (br_hint),
        .target      (br_target),
        .fallthru    (br_fallthru),
        .guess_taken (guess_taken),
        .alt_addr    (alt_addr)
    );

    brc_tracker #(.CR_BITS(CR_BITS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .br_vld        (br_vld),
        .br_idx        (br_idx),
        .br_sense      (br_sense),
        .guess_taken   (guess_taken),
        .alt_addr      (alt_addr),
        .rd_cnt_next   (rd_cnt_next),
        .rd_val_next   (rd_val_next),
        .wb_vld        (wb_vld),
        .wb_idx        (wb_idx),
        .wb_val        (wb_val),
        .br_stall      (br_stall),
        .busy          (busy),
        .res_vld       (res_vld),
        .res_taken     (res_taken),
        .res_spec      (res_spec),
        .flush         (flush),
        .redirect      (redirect),
        .redirect_addr (redirect_addr)
    );
endmodule

// File: rtl/brc_checker.sv
module brc_checker (
    input logic clk,
    input logic rst_n,
    input logic br_vld,
    input logic br_stall,
    input logic busy,
    input logic res_vld,
    input logic res_spec,
    input logic flush,
    input logic redirect
);
    a_r8_stall_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (br_vld && busy) |-> br_stall);

    a_r8_stall_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        br_stall |-> busy);

    a_r8_stalled_gets_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        br_stall |=> !res_vld);

    a_r3_spec_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_spec) |-> busy);

    a_r2_direct_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_spec) |-> !busy);

    a_r7_flush_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> ($past(busy) && !busy));

    a_r7_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    a_r7_redirect_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    a_r6_no_recovery_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy)) |-> !redirect);
endmodule

bind br_resolve_unit brc_checker i_brc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_vld   (br_vld),
    .br_stall (br_stall),
    .busy     (busy),
    .res_vld  (res_vld),
    .res_spec (res_spec),
    .flush    (flush),
    .redirect (redirect)
);

// File: tb/test_br_resolve_unit.sv
module test_br_resolve_unit;
    localparam int NB = 32;
    localparam int CMAX = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_issue_vld, wb_vld, wb_val, br_vld, br_sense, br_backward, br_hint;
    logic [4:0] wr_issue_idx, wb_idx, br_idx;
    logic [31:0] br_target, br_fallthru;
    logic br_stall, busy, res_vld, res_taken, res_spec, flush, redirect;
    logic [31:0] redirect_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    br_resolve_unit i_br_resolve_unit (
        .clk(clk), .rst_n(rst_n),
        .wr_issue_vld(wr_issue_vld), .wr_issue_idx(wr_issue_idx),
        .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_val(wb_val),
        .br_vld(br_vld), .br_idx(br_idx), .br_sense(br_sense),
        .br_backward(br_backward), .br_hint(br_hint),
        .br_target(br_target), .br_fallthru(br_fallthru),
        .br_stall(br_stall), .busy(busy), .res_vld(res_vld),
        .res_taken(res_taken), .res_spec(res_spec), .flush(flush),
        .redirect(redirect), .redirect_addr(redirect_addr)
    );

    // behavioural reference state
    int  m_cnt [NB];
    bit  m_cr  [NB];
    bit  m_busy;
    int  m_owed;
    int  m_idx;
    bit  m_sense, m_guess;
    logic [31:0] m_alt;
    bit  e_vld, e_taken, e_spec, e_flush, e_redir;
    logic [31:0] e_addr;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            foreach (m_cnt[i]) begin m_cnt[i] = 0; m_cr[i] = 0; end
            m_busy = 0; m_owed = 0; e_vld = 0; e_taken = 0; e_spec = 0;
            e_flush = 0; e_redir = 0; e_addr = 0; m_alt = 0; m_idx = 0;
        end else begin
            int nc [NB];
            bit nv [NB];
            foreach (m_cnt[i]) begin nc[i] = m_cnt[i]; nv[i] = m_cr[i]; end
            if (wr_issue_vld && wb_vld && wr_issue_idx == wb_idx) begin
                if (nc[wb_idx] == 0) nc[wb_idx] = 1;
            end else begin
                if (wr_issue_vld && nc[wr_issue_idx] < CMAX) nc[wr_issue_idx]++;
                if (wb_vld && nc[wb_idx] > 0) nc[wb_idx]--;
            end
            if (wb_vld) nv[wb_idx] = wb_val;
            e_vld = 0; e_flush = 0; e_redir = 0;
            if (m_busy) begin
                if (wb_vld && int'(wb_idx) == m_idx && m_owed > 0) begin
                    m_owed--;
                    if (m_owed == 0) begin
                        m_busy = 0;
                        if ((wb_val == m_sense) != m_guess) begin
                            e_flush = 1; e_redir = 1; e_addr = m_alt;
                        end
                    end
                end
            end else if (br_vld) begin
                e_vld = 1;
                if (nc[br_idx] == 0) begin
                    e_spec = 0; e_taken = (nv[br_idx] == br_sense);
                end else begin
                    m_busy = 1; m_owed = nc[br_idx]; m_idx = br_idx;
                    m_sense = br_sense; m_guess = br_backward ^ br_hint;
                    m_alt = m_guess ? br_fallthru : br_target;
                    e_spec = 1; e_taken = m_guess;
                end
            end
            foreach (m_cnt[i]) begin m_cnt[i] = nc[i]; m_cr[i] = nv[i]; end
        end
    end

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", what, got, exp, cycles);
        end
    endtask

    task automatic clr();
        wr_issue_vld = 0; wr_issue_idx = 0; wb_vld = 0; wb_idx = 0; wb_val = 0;
        br_vld = 0; br_idx = 0; br_sense = 0; br_backward = 0; br_hint = 0;
        br_target = 0; br_fallthru = 0;
    endtask

    // one clock: check the combinational stall, clock, compare registered outputs
    task automatic tick();
        #1;
        chk("R8 br_stall", br_stall, br_vld && m_busy);
        @(posedge clk);
        @(negedge clk);
        chk("R2 res_vld", res_vld, e_vld);
        if (e_vld) begin
            chk("R3 res_spec", res_spec, e_spec);
            chk("R2 res_taken", res_taken, e_taken);
        end
        chk("R6 busy", busy, m_busy);
        chk("R7 flush", flush, e_flush);
        chk("R7 redirect", redirect, e_redir);
        if (e_redir) chk("R7 redirect_addr", redirect_addr, e_addr);
    endtask

    task automatic branch(input int idx, input bit sense, input bit back, input bit hint,
                          input logic [31:0] tgt, input logic [31:0] ft);
        br_vld = 1; br_idx = idx[4:0]; br_sense = sense; br_backward = back;
        br_hint = hint; br_target = tgt; br_fallthru = ft;
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 busy", busy, 0);
        chk("R1 res_vld", res_vld, 0);
        chk("R1 flush", flush, 0);
        chk("R1 redirect", redirect, 0);
        chk("R1 br_stall", br_stall, 0);

        // R2: bit 3 idle and zero, sense 0 -> taken, direct
        branch(3, 0, 1, 0, 32'h40, 32'h44); tick(); clr();
        chk("R2 direct taken", res_taken, 1);
        chk("R2 direct not spec", res_spec, 0);

        // R3 + R6: pending bit 5, backward -> guess taken, value 1 agrees
        wr_issue_vld = 1; wr_issue_idx = 5; tick(); clr();
        branch(5, 1, 1, 0, 32'h100, 32'h104); tick(); clr();
        chk("R3 spec flag", res_spec, 1);
        chk("R3 guess taken", res_taken, 1);
        chk("R3 busy", busy, 1);
        wb_vld = 1; wb_idx = 5; wb_val = 1; tick(); clr();
        chk("R6 retired", busy, 0);
        chk("R6 no flush", flush, 0);

        // R7 + R8: forward with hint -> guess taken, value disagrees
        wr_issue_vld = 1; wr_issue_idx = 7; tick(); clr();
        branch(7, 1, 0, 1, 32'h200, 32'h204); tick(); clr();
        chk("R3 hint inverts", res_taken, 1);
        branch(2, 0, 0, 0, 32'h300, 32'h304); tick();
        chk("R8 stalled no result", res_vld, 0);
        clr();
        wb_vld = 1; wb_idx = 7; wb_val = 0; tick(); clr();
        chk("R7 flush", flush, 1);
        chk("R7 redirect", redirect, 1);
        chk("R7 alt address", redirect_addr, 32'h204);
        tick();
        chk("R7 flush one cycle", flush, 0);

        // R4: last writeback forwarded in the branch cycle
        wr_issue_vld = 1; wr_issue_idx = 9; tick(); clr();
        branch(9, 1, 1, 0, 32'h500, 32'h504);
        wb_vld = 1; wb_idx = 9; wb_val = 0; tick(); clr();
        chk("R4 no speculation", res_spec, 0);
        chk("R4 forwarded value", res_taken, 0);

        // R9: younger writer does not delay resolution
        wr_issue_vld = 1; wr_issue_idx = 11; tick(); clr();
        branch(11, 1, 0, 0, 32'h600, 32'h604); tick(); clr();
        wr_issue_vld = 1; wr_issue_idx = 11; tick(); clr();
        wb_vld = 1; wb_idx = 11; wb_val = 1; tick(); clr();
        chk("R9 resolved early", busy, 0);
        chk("R9 mispredict flush", flush, 1);
        chk("R9 alt is target", redirect_addr, 32'h600);
        wb_vld = 1; wb_idx = 11; wb_val = 1; tick(); clr();

        // R5: two older writers, one writeback is not enough
        wr_issue_vld = 1; wr_issue_idx = 13; tick(); tick(); clr();
        branch(13, 0, 1, 0, 32'h700, 32'h704); tick(); clr();
        wb_vld = 1; wb_idx = 13; wb_val = 0; tick(); clr();
        chk("R5 still interlocked", busy, 1);
        wb_vld = 1; wb_idx = 13; wb_val = 0; tick(); clr();
        chk("R5 clears after second", busy, 0);
        chk("R5 agreeing no flush", flush, 0);
        // R5: issue and writeback together keep the count at one
        wr_issue_vld = 1; wr_issue_idx = 14; tick(); clr();
        wr_issue_vld = 1; wr_issue_idx = 14; wb_vld = 1; wb_idx = 14; wb_val = 1; tick(); clr();
        branch(14, 1, 1, 0, 32'h800, 32'h804); tick(); clr();
        chk("R5 net unchanged", res_spec, 1);
        wb_vld = 1; wb_idx = 14; wb_val = 1; tick(); clr();

        // R10: stray writeback updates value only
        wb_vld = 1; wb_idx = 20; wb_val = 1; tick(); clr();
        branch(20, 1, 0, 0, 32'h900, 32'h904); tick(); clr();
        chk("R10 no interlock", res_spec, 0);
        chk("R10 value written", res_taken, 1);

        // randomized stream on a few bits, compared with the model each cycle
        for (int n = 0; n < 4000; n++) begin
            int b;
            clr();
            if ($urandom_range(0, 2) == 0) begin
                b = $urandom_range(0, 3);
                if (m_cnt[b] < CMAX - 1) begin wr_issue_vld = 1; wr_issue_idx = b[4:0]; end
            end
            if ($urandom_range(0, 2) == 0) begin
                b = $urandom_range(0, 3);
                if (m_cnt[b] > 0 || $urandom_range(0, 7) == 0) begin
                    wb_vld = 1; wb_idx = b[4:0]; wb_val = 1'($urandom_range(0, 1));
                end
            end
            if ($urandom_range(0, 1) == 0)
                branch($urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)), $urandom, $urandom);
            tick();
        end
        clr();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule